// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a prescaler-rate clock by a programmable ratio N and emits one single-cycle pulse per N input cycles. It is the feedback divider of a PLL. Internally a prescaler counts either P or P+1 input cycles per stage period. A main counter runs for B stage periods per output period. A swallow counter picks P+1 for the first A of those stage periods, so that N = P*B + A in dual-modulus mode. Fixed modes use P for every stage period, and a bypass mode removes the main counter so that N = P.

The configuration is presented as plain input levels: mode, swallow count A, main count B and a bypass bit. The block checks it continuously and raises an error flag for illegal combinations. A setting is copied into the active registers only at a terminal count, so a divide period is never cut short. Three sources hold the counters parked:
- a dedicated counter-hold bit;
- a shared hold bit;
- an external sync input, which acts only when its registered enable is on.

The hold bits are levels, not self-clearing.

Top module: `fbdiv_top`

## Requirements
- R1: Mode encodings 3, 4, 5, 6 and 7 are dual-modulus with P = 2, 4, 8, 16 and 32 (prescaler alternates P+1 and P). With bypass low, a legal setting divides by N = P*B + A.
- R2: Mode encodings 0, 1 and 2 are fixed with P = 1, 2 and 3. With bypass low they divide by N = P*B, and the swallow count A is ignored: it neither changes N nor raises the error flag.
- R3: With bypass high and A = 0, the divide ratio equals P alone for every mode, giving the ratios 1, 2, 3, 4, 8, 16 and 32. B is ignored in this case.
- R4: With bypass low, a main count B below 3 raises `cfg_err` (combinationally, from the current inputs).
- R5: In a dual-modulus mode with bypass low, A >= B raises `cfg_err`. A = 0 is legal and means no P+1 periods.
- R6: With bypass high, any nonzero A raises `cfg_err`.
- R7: A setting that is illegal at a terminal count is not loaded. The divider keeps its previous active ratio.
- R8: A change to the inputs in mid-period does not affect the period in progress. A legal new ratio takes effect starting with the period after the next pulse.
- R9: `div_pulse` is high for exactly one cycle per period, with no dead cycle between periods. After counting resumes, the first pulse is visible after the N-th clock edge.
- R10: While `ab_hold` or `rab_hold` is high, `div_pulse` stays low and the counters stay parked. After release the first pulse follows N edges later.
- R11: `sync_in` high parks the counters like a hold bit only when the registered copy of `sync_en` is set. With `sync_en` low, `sync_in` has no effect on the pulse train.
- R12: After `rst_n` low, the sync enable is off and the active setting is divide-by-1 bypass. With an illegal input setting, pulses then appear on every cycle, and no pulse appears while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler-input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_mode | input | 3 | Prescaler mode encoding (see R1, R2) |
| swallow_cnt | input | A_W | Swallow count A |
| main_cnt | input | B_W | Main count B |
| b_bypass | input | 1 | Bypass main counter, N = P |
| ab_hold | input | 1 | Dedicated counter hold level |
| rab_hold | input | 1 | Shared hold level |
| sync_in | input | 1 | External sync, active high |
| sync_en | input | 1 | Enable for sync_in, registered |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |
| cfg_err | output | 1 | Current input setting is illegal |

## Verification
The assertions take for granted that all control inputs are synchronous to `clk` and change only between edges. They also assume that the hold and sync levels are ordinary levels, not glitches. The stimulus respects this by driving every input at the falling edge. It draws random settings with B capped at 12 and A at 7, including illegal ones, so that periods stay short. Hold pulses of a few cycles restart the counters between random settings.

// File: rtl/fbdiv_pkg.sv
// Shared types and helpers for the dual-modulus feedback divider.
// Assumes the 3-bit mode encoding below is fixed across the code base.
package fbdiv_pkg;

    typedef enum logic [2:0] {
        MODE_FIX1 = 3'd0,
        MODE_FIX2 = 3'd1,
        MODE_FIX3 = 3'd2,
        MODE_DM2  = 3'd3,
        MODE_DM4  = 3'd4,
        MODE_DM8  = 3'd5,
        MODE_DM16 = 3'd6,
        MODE_DM32 = 3'd7
    } fbdiv_mode_e;

    localparam int P_MAX = 33;
    localparam int P_W   = $clog2(P_MAX + 1);

    // Base prescaler modulus P for a mode.
    function automatic logic [P_W-1:0] presc_base(input fbdiv_mode_e m);
        case (m)
            MODE_FIX1: presc_base = P_W'(1);
            MODE_FIX2: presc_base = P_W'(2);
            MODE_FIX3: presc_base = P_W'(3);
            MODE_DM2:  presc_base = P_W'(2);
            MODE_DM4:  presc_base = P_W'(4);
            MODE_DM8:  presc_base = P_W'(8);
            MODE_DM16: presc_base = P_W'(16);
            default:   presc_base = P_W'(32);
        endcase
    endfunction

    // True when the mode alternates P+1 and P.
    function automatic logic is_dual(input fbdiv_mode_e m);
        is_dual = (m >= MODE_DM2);
    endfunction

endpackage

// File: rtl/fbdiv_cfg_check.sv
// Decodes the prescaler mode and judges the legality of a setting.
// Purely combinational; assumes inputs are stable around clock edges.
module fbdiv_cfg_check
    import fbdiv_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic [2:0]     mode_i,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    input  logic           byp_i,
    output logic           legal_o,
    output logic [P_W-1:0] p_o,
    output logic           dual_o
);

    fbdiv_mode_e mode_e;

    // Decode mode into modulus and dual flag, then apply legality rules.
    always_comb begin
        mode_e = fbdiv_mode_e'(mode_i);
        p_o    = presc_base(mode_e);
        dual_o = is_dual(mode_e);
        if (byp_i) begin
            legal_o = (a_i == '0);
        end else begin
            legal_o = (32'(b_i) >= 32'd3) &&
                      (!dual_o || (32'(a_i) < 32'(b_i)));
        end
    end

endmodule

// File: rtl/fbdiv_prescaler.sv
// Prescaler stage: counts P or P+1 input cycles per stage period and
// flags the last cycle of each. Parks at a period end while held.
// Assumes p_i >= 1 and p_i + 1 <= P_MAX.
module fbdiv_prescaler
    import fbdiv_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold_i,
    input  logic [P_W-1:0] p_i,
    input  logic           use_p1_i,
    output logic           pre_end_o
);

    logic [P_W-1:0] pre_cnt;

    assign pre_end_o = (pre_cnt == '0);

    // Down-counter reloaded with modulus-1 at each stage period end.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            pre_cnt <= '0;
        end else if (pre_end_o) begin
            pre_cnt <= use_p1_i ? p_i : (p_i - P_W'(1));
        end else begin
            pre_cnt <= pre_cnt - P_W'(1);
        end
    end

    // The stage counter never exceeds the largest modulus minus one.
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pre_cnt) < P_MAX);

endmodule

// File: rtl/fbdiv_swallow.sv
// Main (B) and swallow (A) counters. Counts stage periods; the first A
// periods of an output period use P+1. Reports the terminal count and
// the modulus choice for the next stage period. Parks at a terminal.
module fbdiv_swallow #(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold_i,
    input  logic           pre_end_i,
    input  logic [A_W-1:0] ld_a_i,
    input  logic [B_W-1:0] ld_b_i,
    input  logic           ld_dual_i,
    input  logic           ld_byp_i,
    output logic           term_o,
    output logic           use_p1_o
);

    logic [A_W-1:0] a_rem, a_nxt;
    logic [B_W-1:0] b_rem, b_nxt;

    assign term_o = pre_end_i && (b_rem == B_W'(1));

    // Next-state of the counters at a stage period end or terminal.
    always_comb begin
        a_nxt = a_rem;
        b_nxt = b_rem;
        if (pre_end_i) begin
            if (term_o) begin
                a_nxt = (ld_dual_i && !ld_byp_i) ? ld_a_i : '0;
                b_nxt = ld_byp_i ? B_W'(1) : ld_b_i;
            end else begin
                b_nxt = b_rem - B_W'(1);
                a_nxt = (a_rem != '0) ? (a_rem - A_W'(1)) : '0;
            end
        end
        use_p1_o = (a_nxt != '0);
    end

    // Counter registers; park at the terminal state while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            a_rem <= '0;
            b_rem <= B_W'(1);
        end else begin
            a_rem <= a_nxt;
            b_rem <= b_nxt;
        end
    end

    // Swallow periods always fit inside the remaining main periods.
    p_swallow_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(a_rem) < 32'(b_rem));

    // The main counter never wraps through zero, so no dead cycle.
    p_b_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        b_rem != '0);

endmodule

// File: rtl/fbdiv_top.sv
// Dual-modulus feedback divider top. Holds the active setting, loads a
// new one only at a terminal count when legal, combines the hold
// sources and gates the output pulse. All inputs synchronous to clk.
module fbdiv_top
    import fbdiv_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     presc_mode,
    input  logic [A_W-1:0] swallow_cnt,
    input  logic [B_W-1:0] main_cnt,
    input  logic           b_bypass,
    input  logic           ab_hold,
    input  logic           rab_hold,
    input  logic           sync_in,
    input  logic           sync_en,
    output logic           div_pulse,
    output logic           cfg_err
);

    logic           in_legal, in_dual;
    logic [P_W-1:0] in_p;

    logic [P_W-1:0] act_p;
    logic           act_dual, act_byp;
    logic [A_W-1:0] act_a;
    logic [B_W-1:0] act_b;

    logic           sync_en_q, running;
    logic           hold, term, use_p1, pre_end, load_ok;

    logic [P_W-1:0] sel_p;
    logic           sel_dual, sel_byp;
    logic [A_W-1:0] sel_a;
    logic [B_W-1:0] sel_b;

    fbdiv_cfg_check #(.A_W(A_W), .B_W(B_W)) chk_i (
        .mode_i  (presc_mode),
        .a_i     (swallow_cnt),
        .b_i     (main_cnt),
        .byp_i   (b_bypass),
        .legal_o (in_legal),
        .p_o     (in_p),
        .dual_o  (in_dual)
    );

    assign cfg_err = !in_legal;
    assign hold    = ab_hold || rab_hold || (sync_in && sync_en_q);
    assign load_ok = term && !hold && in_legal;

    // Setting used for the next period: new inputs only on a legal load.
    always_comb begin
        if (load_ok) begin
            sel_p = in_p;  sel_dual = in_dual; sel_byp = b_bypass;
            sel_a = swallow_cnt; sel_b = main_cnt;
        end else begin
            sel_p = act_p; sel_dual = act_dual; sel_byp = act_byp;
            sel_a = act_a; sel_b = act_b;
        end
    end

    fbdiv_prescaler pre_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (hold),
        .p_i       (sel_p),
        .use_p1_i  (use_p1),
        .pre_end_o (pre_end)
    );

    fbdiv_swallow #(.A_W(A_W), .B_W(B_W)) swl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (hold),
        .pre_end_i (pre_end),
        .ld_a_i    (sel_a),
        .ld_b_i    (sel_b),
        .ld_dual_i (sel_dual),
        .ld_byp_i  (sel_byp),
        .term_o    (term),
        .use_p1_o  (use_p1)
    );

    // Active setting: divide-by-1 bypass after reset, loaded on terminal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_p <= P_W'(1); act_dual <= 1'b0; act_byp <= 1'b1;
            act_a <= '0;      act_b    <= B_W'(1);
        end else if (load_ok) begin
            act_p <= in_p;        act_dual <= in_dual; act_byp <= b_bypass;
            act_a <= swallow_cnt; act_b    <= main_cnt;
        end
    end

    // Registered sync enable, off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_en_q <= 1'b0;
        else        sync_en_q <= sync_en;
    end

    // Running flag masks the parked terminal state from the output.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) running <= 1'b0;
        else                running <= 1'b1;
    end

    assign div_pulse = term && running;

    // No pulse in the cycle after any hold source was active.
    p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !div_pulse);

    // The active setting only moves at a terminal count.
    p_cfg_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !term |=> ($stable(act_p) && $stable(act_a) && $stable(act_b) &&
                   $stable(act_byp) && $stable(act_dual)));

    // An illegal setting at a terminal count leaves the active one alone.
    p_illegal_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (term && cfg_err) |=> ($stable(act_p) && $stable(act_b) &&
                               $stable(act_a) && $stable(act_byp)));

endmodule

// File: tb/fbdiv_top_tb.sv
`timescale 1ns/1ps
module fbdiv_top_tb_top;

    localparam int A_W = 6;
    localparam int B_W = 13;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [2:0]     presc_mode;
    logic [A_W-1:0] swallow_cnt;
    logic [B_W-1:0] main_cnt;
    logic           b_bypass, ab_hold, rab_hold, sync_in, sync_en;
    logic           div_pulse, cfg_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cur_n = 1;

    always #2 clk = ~clk;

    fbdiv_top #(.A_W(A_W), .B_W(B_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .presc_mode(presc_mode),
        .swallow_cnt(swallow_cnt), .main_cnt(main_cnt), .b_bypass(b_bypass),
        .ab_hold(ab_hold), .rab_hold(rab_hold), .sync_in(sync_in),
        .sync_en(sync_en), .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: cycles %0d expected below 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int p_of(int m);
        case (m)
            0: return 1;  1: return 2;  2: return 3;  3: return 2;
            4: return 4;  5: return 8;  6: return 16; default: return 32;
        endcase
    endfunction

    function automatic int n_of(int m, int a, int b, bit byp);
        if (byp) return p_of(m);
        if (m >= 3) return p_of(m) * b + a;
        return p_of(m) * b;
    endfunction

    function automatic bit legal_of(int m, int a, int b, bit byp);
        if (byp) return (a == 0);
        return (b >= 3) && ((m < 3) || (a < b));
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(int m, int a, int b, bit byp);
        presc_mode  = 3'(m);
        swallow_cnt = A_W'(a);
        main_cnt    = B_W'(b);
        b_bypass    = byp;
    endtask

    // Called at a falling edge; counts edges until the pulse is seen.
    task automatic wait_pulse(output int cnt);
        cnt = 0;
        do begin
            @(posedge clk); @(negedge clk);
            cnt++;
        end while (!div_pulse && cnt < 3000);
        if (!div_pulse) cnt = -1;
    endtask

    // Two-cycle dedicated hold, releasing at a falling edge.
    task automatic restart();
        ab_hold = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        ab_hold = 1'b0;
    endtask

    task automatic expect_periods(int n, string req);
        int got;
        for (int k = 0; k < 2; k++) begin
            wait_pulse(got);
            check(got == n, req, got, n);
        end
    endtask

    // Apply a setting under hold and update the model of the active ratio.
    task automatic run_cfg(int m, int a, int b, bit byp, string req);
        set_cfg(m, a, b, byp);
        #1;
        check(cfg_err == !legal_of(m, a, b, byp),
              byp ? "R6" : ((b < 3) ? "R4" : "R5"),
              cfg_err, !legal_of(m, a, b, byp));
        if (legal_of(m, a, b, byp)) cur_n = n_of(m, a, b, byp);
        restart();
        expect_periods(cur_n, legal_of(m, a, b, byp) ? req : "R7");
    endtask

    initial begin
        int got, sd;
        sd = $urandom(32'h5EED_0B1E);
        rst_n = 1'b0; ab_hold = 1'b0; rab_hold = 1'b0;
        sync_in = 1'b0; sync_en = 1'b1;
        set_cfg(0, 0, 0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            check(div_pulse == 1'b0, "R12 quiet in reset", div_pulse, 0);
        end
        check(cfg_err == 1'b1, "R4 B=0 flagged", cfg_err, 1);
        sync_en = 1'b0;
        rst_n = 1'b1;
        // R12: default active setting divides by one.
        expect_periods(1, "R12");

        // N = 12 from three different settings.
        run_cfg(1, 0, 6, 1'b0, "R2");
        run_cfg(3, 0, 6, 1'b0, "R1");
        run_cfg(4, 0, 3, 1'b0, "R1");
        run_cfg(4, 2, 5, 1'b0, "R1");
        run_cfg(7, 2, 3, 1'b0, "R1");
        // R2: A ignored in fixed mode, even when larger than B.
        run_cfg(2, 9, 4, 1'b0, "R2");
        // R3: every bypass ratio.
        for (int m = 0; m < 8; m++) run_cfg(m, 0, 0, 1'b1, "R3");
        // R4, R5, R6 illegal settings keep the previous ratio (R7).
        run_cfg(4, 0, 2, 1'b0, "R4");
        run_cfg(5, 4, 4, 1'b0, "R5");
        run_cfg(3, 1, 5, 1'b1, "R6");

        // R8: mid-period change; the current period keeps its ratio.
        run_cfg(4, 0, 5, 1'b0, "R1");
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        set_cfg(2, 0, 3, 1'b0);
        wait_pulse(got);
        check(got + 2 == 20, "R8 period in progress", got + 2, 20);
        wait_pulse(got);
        check(got == 9, "R8 new ratio next", got, 9);
        cur_n = 9;

        // R7: illegal change in mid-period, old ratio retained.
        @(posedge clk); @(negedge clk);
        set_cfg(5, 0, 1, 1'b0);
        wait_pulse(got);
        check(got + 1 == 9, "R7 period", got + 1, 9);
        wait_pulse(got);
        check(got == 9, "R7 kept ratio", got, 9);

        // R9 and R10: short ratio, shared hold mid-stream.
        run_cfg(4, 0, 0, 1'b1, "R3");
        @(posedge clk); @(negedge clk);
        check(div_pulse == 1'b0, "R9 single-cycle pulse", div_pulse, 0);
        rab_hold = 1'b1;
        got = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); @(negedge clk);
            if (div_pulse) got++;
        end
        check(got == 0, "R10 no pulse while held", got, 0);
        rab_hold = 1'b0;
        wait_pulse(got);
        check(got == 4, "R10 restart after release", got, 4);

        // R11: sync ignored when disabled, restarts when enabled.
        run_cfg(4, 0, 5, 1'b0, "R1");
        sync_in = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
        end
        sync_in = 1'b0;
        wait_pulse(got);
        check(got + 3 == 20, "R11 sync ignored when disabled", got + 3, 20);
        sync_en = 1'b1;
        @(posedge clk); @(negedge clk);
        sync_in = 1'b1;
        @(posedge clk); @(negedge clk);
        check(div_pulse == 1'b0, "R11 sync parks", div_pulse, 0);
        sync_in = 1'b0;
        wait_pulse(got);
        check(got == 20, "R11 restart after sync", got, 20);
        sync_en = 1'b0;

        // Random settings, legal and illegal, against the bench model.
        for (int t = 0; t < 60; t++) begin
            int m, a, b;
            bit byp;
            m   = int'($urandom_range(0, 7));
            byp = ($urandom_range(0, 7) == 0);
            a   = byp ? int'($urandom_range(0, 1)) : int'($urandom_range(0, 7));
            b   = int'($urandom_range(0, 12));
            run_cfg(m, a, b, byp, byp ? "R3" : ((m < 3) ? "R2" : "R1"));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule